// File: doc/BRIEF.md
# Codirectional 64 kbit/s Line Encoder with Byte Slip

This block is the transmit half of a codirectional 64 kbit/s data adapter. Once per frame it captures an eight-bit burst from a serial PCM bus clocked at 2.048 MHz. Which of two frame positions it takes is chosen by a pair of time-slot envelopes and a select line. The captured octet is then sent as a continuous dual-rail line stream, timed by a separate 256 kHz clock that has no fixed phase relation to the PCM clock.

Each bit fills four line-clock periods, called unit intervals. A zero and a one get different patterns, and consecutive bits go out on alternating rails. The last bit of every octet repeats the polarity of the bit before it, so the far end can recover octet boundaries. An alarm input suppresses that mark.

The two clocks may drift apart. The block absorbs the drift a whole byte at a time: a byte that arrives too early overwrites the waiting one and raises a delete flag. A byte that is missing is covered by sending the previous byte once more with an insert flag. After that repeat the line goes idle.

Top module: `cdir_line_encoder`

## Requirements
- R1: While reset is applied and after it is released with no byte captured, both rail outputs are high (idle) and both flags are low.
- R2: A byte is captured from `pcm_din` on eight rising `pcm_clk` edges while the selected envelope is high. `slot_pick` high selects `slot_env_a` and low selects `slot_env_b`. A burst on the unselected envelope leaves the line output unchanged.
- R3: Each bit lasts four `line_clk` periods and the first captured bit is sent first. On its rail, a 1 gives the levels low, low, high, high and a 0 gives low, high, low, high. The other rail stays high, and both rails are never low together.
- R4: Consecutive bit blocks use opposite rails, and the first block after reset uses the positive rail (`rail_pos_n`).
- R5: The eighth bit of an octet uses the same rail as the seventh. If `alarm_hold` is high at the line edge that starts the eighth bit, the eighth bit uses the opposite rail instead.
- R6: A captured byte can be used from the third `line_clk` rising edge after the `pcm_clk` edge that took its last bit. It starts on the next line edge if the line is idle, otherwise right after the current octet ends. The waiting byte is never changed while it is being moved into the output stage.
- R7: If a byte becomes available while an earlier byte is still waiting and is not being moved to the output stage on that edge, the new byte replaces it. `delete_flag` is then high for exactly one `line_clk` period.
- R8: If no byte is waiting when a freshly loaded octet ends, that octet is sent once more. `insert_flag` is high for all 32 line periods of the repeat.
- R9: If no byte is waiting when a repeated octet ends, both rails stay high and `insert_flag` is low. The next octet then starts on the rail opposite to the last block sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside each clock domain |
| pcm_clk | input | 1 | 2.048 MHz PCM bus clock |
| pcm_din | input | 1 | Serial PCM data, sampled on rising `pcm_clk` |
| slot_env_a | input | 1 | Time-slot envelope, first position |
| slot_env_b | input | 1 | Time-slot envelope, second position |
| slot_pick | input | 1 | Envelope select: 1 = `slot_env_a`, 0 = `slot_env_b` |
| line_clk | input | 1 | 256 kHz line clock, one unit interval per period |
| alarm_hold | input | 1 | High suppresses the octet-boundary polarity mark |
| rail_pos_n | output | 1 | Positive rail, active low |
| rail_neg_n | output | 1 | Negative rail, active low |
| insert_flag | output | 1 | High while a repeated octet is sent |
| delete_flag | output | 1 | One-period pulse when a waiting byte is overwritten |

## Verification
The checks assume that captures of selected bursts are at least five line periods apart. They also assume that the envelope stays high for exactly eight PCM edges, and that `alarm_hold` changes only away from rising `line_clk` edges. The bench holds to all three. It drives every PCM-side input on falling `pcm_clk` edges. It places the line clock so that its rising edges never coincide with a PCM edge, which makes the synchronizer delay deterministic for the reference model. It also spaces overload bursts six line periods apart.

// File: rtl/cdir_pkg.sv
package cdir_pkg;
  // unit intervals per transmitted bit and the counter width that indexes them
  localparam int UI_PER_BIT = 4;
  localparam int UI_W       = 2;

  // active-low rail level inside a bit block: a one is low for the first half,
  // a zero alternates starting low
  function automatic logic ui_level(input logic bit_val, input logic [UI_W-1:0] ui);
    return bit_val ? ui[1] : ui[0];
  endfunction
endpackage

// File: rtl/cdir_rst_sync.sv
module cdir_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sr_q[STAGES-1];
endmodule

// File: rtl/cdir_slot_capture.sv
module cdir_slot_capture #(
  parameter int OCTET_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               din,
  input  logic               env_a,
  input  logic               env_b,
  input  logic               env_sel,
  output logic [OCTET_W-1:0] byte_o,
  output logic               tgl_o
);
  localparam int CW = $clog2(OCTET_W);
  localparam logic [CW-1:0] LAST_CNT = CW'(OCTET_W - 1);

  logic               env;
  logic               last;
  logic [OCTET_W-1:0] sh_q, sh_d, hold_q, hold_d;
  logic [CW-1:0]      cnt_q, cnt_d;
  logic               tgl_q, tgl_d;

  assign env  = env_sel ? env_a : env_b;
  assign last = env && (cnt_q == LAST_CNT);

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    hold_d = hold_q;
    tgl_d  = tgl_q;
    if (env) begin
      sh_d  = {sh_q[OCTET_W-2:0], din};
      cnt_d = last ? '0 : cnt_q + 1'b1;
    end else begin
      cnt_d = '0;
    end
    if (last) begin
      hold_d = {sh_q[OCTET_W-2:0], din};
      tgl_d  = ~tgl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      hold_q <= '0;
      tgl_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      tgl_q  <= tgl_d;
    end
  end

  assign byte_o = hold_q;
  assign tgl_o  = tgl_q;
endmodule

// File: rtl/cdir_toggle_sync.sv
module cdir_toggle_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tgl_i,
  output logic pulse_o
);
  // STAGES synchronizing flops plus one history flop for edge detection
  logic [STAGES:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-1:0], tgl_i};
  end

  assign pulse_o = sr_q[STAGES] ^ sr_q[STAGES-1];
endmodule

// File: rtl/cdir_line_coder.sv
module cdir_line_coder
  import cdir_pkg::*;
#(
  parameter int OCTET_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arrive_i,
  input  logic [OCTET_W-1:0] byte_i,
  input  logic               alarm_i,
  output logic               pos_n_o,
  output logic               neg_n_o,
  output logic               ins_o,
  output logic               del_o,
  output logic               active_o,
  output logic [UI_W-1:0]    ui_o
);
  localparam int BW = $clog2(OCTET_W);
  localparam logic [BW-1:0]   LAST_BIT = BW'(OCTET_W - 1);
  localparam logic [UI_W-1:0] LAST_UI  = UI_W'(UI_PER_BIT - 1);

  logic [OCTET_W-1:0] latch_q, latch_d, cur_q, cur_d;
  logic               full_q, full_d, act_q, act_d, rep_q, rep_d;
  logic               ins_q, ins_d, del_q, del_d, pol_q, pol_d;
  logic [UI_W-1:0]    ui_q, ui_d;
  logic [BW-1:0]      bidx_q, bidx_d, bidx_nx;
  logic               bit_end, oct_end, bound, take;
  logic [OCTET_W-1:0] shifted;
  logic               bit_val, lvl;

  assign bit_end = (ui_q == LAST_UI);
  assign oct_end = bit_end && (bidx_q == LAST_BIT);
  assign bound   = !act_q || oct_end;
  assign take    = bound && full_q;
  assign bidx_nx = bidx_q + 1'b1;

  always_comb begin
    latch_d = latch_q;
    full_d  = full_q;
    cur_d   = cur_q;
    act_d   = act_q;
    rep_d   = rep_q;
    ins_d   = ins_q;
    pol_d   = pol_q;
    ui_d    = ui_q;
    bidx_d  = bidx_q;
    // storage: a new byte lands even on a transfer edge; the old one moves out
    del_d = arrive_i && full_q && !take;
    if (arrive_i) begin
      latch_d = byte_i;
      full_d  = 1'b1;
    end else if (take) begin
      full_d = 1'b0;
    end
    // encoder sequencing
    if (!bound) begin
      if (bit_end) begin
        ui_d   = '0;
        bidx_d = bidx_nx;
        pol_d  = (bidx_nx == LAST_BIT && !alarm_i) ? pol_q : ~pol_q;
      end else begin
        ui_d = ui_q + 1'b1;
      end
    end else begin
      ui_d   = '0;
      bidx_d = '0;
      if (act_q) pol_d = ~pol_q;
      if (full_q) begin
        cur_d = latch_q;
        act_d = 1'b1;
        ins_d = 1'b0;
        rep_d = 1'b1;
      end else if (act_q && rep_q) begin
        ins_d = 1'b1;
        rep_d = 1'b0;
      end else begin
        act_d = 1'b0;
        ins_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      full_q  <= 1'b0;
      cur_q   <= '0;
      act_q   <= 1'b0;
      rep_q   <= 1'b0;
      ins_q   <= 1'b0;
      del_q   <= 1'b0;
      pol_q   <= 1'b0;
      ui_q    <= '0;
      bidx_q  <= '0;
    end else begin
      latch_q <= latch_d;
      full_q  <= full_d;
      cur_q   <= cur_d;
      act_q   <= act_d;
      rep_q   <= rep_d;
      ins_q   <= ins_d;
      del_q   <= del_d;
      pol_q   <= pol_d;
      ui_q    <= ui_d;
      bidx_q  <= bidx_d;
    end
  end

  assign shifted  = cur_q << bidx_q;
  assign bit_val  = shifted[OCTET_W-1];
  assign lvl      = ui_level(bit_val, ui_q);
  assign pos_n_o  = (act_q && !pol_q) ? lvl : 1'b1;
  assign neg_n_o  = (act_q &&  pol_q) ? lvl : 1'b1;
  assign ins_o    = ins_q;
  assign del_o    = del_q;
  assign active_o = act_q;
  assign ui_o     = ui_q;
endmodule

// File: rtl/cdir_line_encoder.sv
module cdir_line_encoder
  import cdir_pkg::*;
#(
  parameter int OCTET_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic rst_n,
  input  logic pcm_clk,
  input  logic pcm_din,
  input  logic slot_env_a,
  input  logic slot_env_b,
  input  logic slot_pick,
  input  logic line_clk,
  input  logic alarm_hold,
  output logic rail_pos_n,
  output logic rail_neg_n,
  output logic insert_flag,
  output logic delete_flag
);
  logic               p_rst_n, l_rst_n;
  logic [OCTET_W-1:0] cap_byte;
  logic               cap_tgl, arrive, l_active;
  logic [UI_W-1:0]    l_ui;

  cdir_rst_sync #(.STAGES(SYNC_STAGES)) u_prst (
    .clk(pcm_clk), .arst_n(rst_n), .rst_n_o(p_rst_n)
  );

  cdir_rst_sync #(.STAGES(SYNC_STAGES)) u_lrst (
    .clk(line_clk), .arst_n(rst_n), .rst_n_o(l_rst_n)
  );

  cdir_slot_capture #(.OCTET_W(OCTET_W)) u_cap (
    .clk(pcm_clk), .rst_n(p_rst_n), .din(pcm_din),
    .env_a(slot_env_a), .env_b(slot_env_b), .env_sel(slot_pick),
    .byte_o(cap_byte), .tgl_o(cap_tgl)
  );

  cdir_toggle_sync #(.STAGES(SYNC_STAGES)) u_xing (
    .clk(line_clk), .rst_n(l_rst_n), .tgl_i(cap_tgl), .pulse_o(arrive)
  );

  cdir_line_coder #(.OCTET_W(OCTET_W)) u_coder (
    .clk(line_clk), .rst_n(l_rst_n), .arrive_i(arrive), .byte_i(cap_byte),
    .alarm_i(alarm_hold), .pos_n_o(rail_pos_n), .neg_n_o(rail_neg_n),
    .ins_o(insert_flag), .del_o(delete_flag), .active_o(l_active), .ui_o(l_ui)
  );
endmodule

// File: rtl/cdir_enc_chk.sv
module cdir_enc_chk
  import cdir_pkg::*;
(
  input logic            lclk,
  input logic            lrst_n,
  input logic            pos_n,
  input logic            neg_n,
  input logic            ins,
  input logic            del,
  input logic            active,
  input logic [UI_W-1:0] ui
);
  // R3
  rails_exclusive_chk: assert property (@(posedge lclk) disable iff (!lrst_n)
    !(!pos_n && !neg_n));

  // R3
  ui_step_chk: assert property (@(posedge lclk) disable iff (!lrst_n)
    (active && $past(active) && $past(ui) != 2'd3) |-> (ui == 2'($past(ui) + 2'd1)));

  // R4
  block_start_chk: assert property (@(posedge lclk) disable iff (!lrst_n)
    (active && ui == '0) |-> (pos_n ^ neg_n));

  // R7
  del_pulse_chk: assert property (@(posedge lclk) disable iff (!lrst_n)
    del |=> !del);

  // R8
  ins_start_chk: assert property (@(posedge lclk) disable iff (!lrst_n)
    $rose(ins) |-> !(pos_n && neg_n));

  // R9
  idle_high_chk: assert property (@(posedge lclk) disable iff (!lrst_n)
    !active |-> (pos_n && neg_n && !ins));
endmodule

bind cdir_line_encoder cdir_enc_chk u_chk (
  .lclk(line_clk), .lrst_n(l_rst_n), .pos_n(rail_pos_n), .neg_n(rail_neg_n),
  .ins(insert_flag), .del(delete_flag), .active(l_active), .ui(l_ui)
);

// File: tb/sim_cdir_line_encoder.sv
`timescale 1ns/1ps
module sim_cdir_line_encoder;
  logic rst_n, pcm_clk, pcm_din, slot_env_a, slot_env_b, slot_pick;
  logic line_clk, alarm_hold;
  logic rail_pos_n, rail_neg_n, insert_flag, delete_flag;

  cdir_line_encoder u0 (
    .rst_n(rst_n), .pcm_clk(pcm_clk), .pcm_din(pcm_din),
    .slot_env_a(slot_env_a), .slot_env_b(slot_env_b), .slot_pick(slot_pick),
    .line_clk(line_clk), .alarm_hold(alarm_hold),
    .rail_pos_n(rail_pos_n), .rail_neg_n(rail_neg_n),
    .insert_flag(insert_flag), .delete_flag(delete_flag)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit done = 0, cmp_on = 0;
  int ins_rises = 0, del_rises = 0;
  logic prev_ins = 0, prev_del = 0;

  // 50 MHz PCM-side clock: rising edges at 10 mod 20 ns
  initial begin pcm_clk = 0; forever #10 pcm_clk = ~pcm_clk; end
  // line clock: rising edges at 85 mod 160 ns, never on a PCM edge
  initial begin line_clk = 0; #85; forever begin line_clk = 1; #80; line_clk = 0; #80; end end

  // behavioural reference model
  int pend_cnt[$];
  logic [7:0] pend_val[$];
  int m_act, m_q, m_b, m_pol, m_ins, m_rep, m_full, m_del, m_valarm;
  logic [7:0] m_cur, m_lat;

  always @(posedge line_clk) begin
    if (!rst_n) begin
      m_act = 0; m_q = 0; m_b = 0; m_pol = 0; m_ins = 0; m_rep = 0;
      m_full = 0; m_del = 0; m_valarm = 0; m_cur = 0; m_lat = 0;
    end else begin
      int arrive, bnd, take;
      logic [7:0] nv;
      arrive = 0; nv = 0;
      foreach (pend_cnt[i]) pend_cnt[i] = pend_cnt[i] - 1;
      if (pend_cnt.size() > 0 && pend_cnt[0] == 0) begin
        arrive = 1; nv = pend_val[0];
        void'(pend_cnt.pop_front()); void'(pend_val.pop_front());
      end
      bnd  = (m_act == 0) || (m_q == 3 && m_b == 7);
      take = bnd && m_full;
      if (!bnd) begin
        if (m_q < 3) m_q++;
        else begin
          m_q = 0; m_b++;
          if (m_b == 7) m_valarm = alarm_hold;
          if (!(m_b == 7 && !alarm_hold)) m_pol = 1 - m_pol;
        end
      end else begin
        if (m_act) m_pol = 1 - m_pol;
        if (m_full) begin m_cur = m_lat; m_act = 1; m_ins = 0; m_rep = 1; end
        else if (m_act && m_rep) begin m_ins = 1; m_rep = 0; end
        else begin m_act = 0; m_ins = 0; end
        m_q = 0; m_b = 0;
      end
      m_del = arrive && m_full && !take;
      if (arrive) begin m_lat = nv; m_full = 1; end
      else if (take) m_full = 0;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  int r7_rail = 2;
  always @(negedge line_clk) begin
    if (cmp_on && !done) begin
      logic ep, en, lv, bv;
      string tag;
      int low_rail;
      if (!m_act) begin ep = 1; en = 1; end
      else begin
        bv = m_cur[7 - m_b];
        lv = bv ? (m_q >= 2) : (m_q % 2 == 1);
        ep = (m_pol == 0) ? lv : 1'b1;
        en = (m_pol == 1) ? lv : 1'b1;
      end
      tag = !m_act ? "R6" : (m_b == 7 ? "R5" : (m_q == 0 ? "R4" : "R3"));
      check(tag, {6'd0, rail_pos_n, rail_neg_n}, {6'd0, ep, en});
      check("R8", {7'd0, insert_flag}, {7'd0, 1'(m_ins)});
      check("R7", {7'd0, delete_flag}, {7'd0, 1'(m_del)});
      // R5: compare the rails of bits 7 and 8 as seen at the block starts
      if (m_act && m_q == 0) begin
        low_rail = !rail_pos_n ? 0 : (!rail_neg_n ? 1 : 2);
        if (m_b == 6) r7_rail = low_rail;
        if (m_b == 7)
          check("R5 violation", {7'd0, 1'(r7_rail == low_rail)}, {7'd0, 1'(m_valarm == 0)});
      end
      if (insert_flag && !prev_ins) ins_rises++;
      if (delete_flag && !prev_del) del_rises++;
      prev_ins = insert_flag;
      prev_del = delete_flag;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge pcm_clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  task automatic wait_pcm(input int n); repeat (n) @(negedge pcm_clk); endtask
  task automatic wait_line(input int n); repeat (n) @(negedge line_clk); endtask

  // caller stands on a falling pcm_clk edge; burst of eight bits, first bit = v[7]
  task automatic send_byte(input logic [7:0] v, input bit on_a, input bit noise);
    slot_pick = on_a;
    for (int i = 0; i < 8; i++) begin
      slot_env_a = on_a | noise;
      slot_env_b = !on_a | noise;
      pcm_din = v[7 - i];
      @(negedge pcm_clk);
    end
    slot_env_a = 0; slot_env_b = 0; pcm_din = 0;
    pend_cnt.push_back(3); pend_val.push_back(v);
  endtask

  // burst on the unselected envelope only
  task automatic stray(input bit pick);
    slot_pick = pick;
    for (int i = 0; i < 8; i++) begin
      slot_env_a = !pick; slot_env_b = pick; pcm_din = i[0];
      @(negedge pcm_clk);
    end
    slot_env_a = 0; slot_env_b = 0; pcm_din = 0;
  endtask

  initial begin
    rst_n = 0; pcm_din = 0; slot_env_a = 0; slot_env_b = 0; slot_pick = 1; alarm_hold = 0;
    wait_pcm(50);
    rst_n = 1;
    wait_line(4);
    // R1: reset state
    check("R1", {4'd0, rail_pos_n, rail_neg_n, insert_flag, delete_flag}, 8'b0000_1100);
    cmp_on = 1;

    // plain flow on slot a: byte queued behind another, then starvation
    @(negedge pcm_clk); send_byte(8'h96, 1, 0);
    wait_pcm(80);       send_byte(8'h3C, 1, 0);
    wait_line(128);
    // R9: idle after the repeat
    check("R9 idle", {5'd0, rail_pos_n, rail_neg_n, insert_flag}, 8'b0000_0110);

    // alarm on, slot b selected, slot a envelope toggling alongside
    alarm_hold = 1;
    @(negedge pcm_clk); send_byte(8'hFF, 0, 1);
    wait_pcm(80);       send_byte(8'h00, 0, 1);
    wait_line(128);
    alarm_hold = 0;

    // R2: bursts on the unselected envelope change nothing
    @(negedge pcm_clk); stray(1'b1);
    wait_pcm(40);       stray(1'b0);
    wait_line(20);
    check("R2 unselected", {6'd0, rail_pos_n, rail_neg_n}, 8'b0000_0011);

    // overload: three captures six line periods apart
    @(negedge pcm_clk); send_byte(8'h81, 1, 0);
    wait_pcm(40);       send_byte(8'h7E, 1, 0);
    wait_pcm(40);       send_byte(8'hC3, 1, 0);
    wait_line(110);

    // steady rate: one byte per octet period
    @(negedge pcm_clk);
    send_byte(8'hA5, 1, 0); wait_pcm(248);
    send_byte(8'h5A, 1, 0); wait_pcm(248);
    send_byte(8'hF0, 1, 0); wait_pcm(248);
    send_byte(8'h0F, 1, 0);
    wait_line(120);

    // R8: one repeat per starvation episode; R7: one overwrite
    check("R8 repeats", 8'(ins_rises), 8'd4);
    check("R7 deletes", 8'(del_rises), 8'd1);
    check("R9 final idle", {6'd0, rail_pos_n, rail_neg_n}, 8'b0000_0011);
    finish_run();
  end
endmodule